// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This block performs one signed arithmetic operation per accepted request on two's-complement operands of `WIDTH` bits (32 by default). A select input picks either the sum of the two sources or the second source minus the first. When the exact mathematical result fits in the signed range, it is delivered unchanged. When it does not fit, the delivered value is pinned to the signed extreme that lies on the same side as the true result.

Every overflow also raises a sticky saturation indicator. That indicator stays high across later clean operations until reset or an explicit clear. The result and its overflow, sign and zero flags are registered, and they appear one clock after the request. A typical use is in an execution stage that writes `resData` to a destination register and lets software poll the sticky indicator after a burst of arithmetic.

Top module: `sat_addsub_unit`

## Requirements
- R1: With `opSub`=0, one cycle after `opValid` is sampled high, `resValid` is 1 and `resData` equals `srcB + srcA` when that sum fits in the signed range.
- R2: With `opSub`=1, the unit computes `srcB - srcA` (second minus first, never the reverse), exact when in range.
- R3: If the true result exceeds the signed range, `resData` is 0x7FFFFFFF when the true result is positive and 0x80000000 when it is negative.
- R4: `flagOvf` is 1 exactly when the operation just delivered overflowed, and 0 for a clean operation.
- R5: Any overflowing operation sets `flagSat`, which then stays 1 through later non-overflowing operations.
- R6: `satClear` sampled high drops `flagSat` at the next edge. An overflowing operation in that same cycle wins and leaves `flagSat` at 1.
- R7: `flagNeg` equals the top bit of the value written and `flagZero` is 1 exactly when the value written is all zeros; both describe the clamped value.
- R8: After reset, `resValid`, `resData`, `flagOvf`, `flagNeg`, `flagZero` and `flagSat` are all 0.
- R9: While `opValid` is low, `resValid` is 0 on the following cycle and `resData` and the flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Request strobe; operands sampled this cycle |
| opSub | input | 1 | 0 = add, 1 = subtract (srcB - srcA) |
| srcA | input | WIDTH | First source operand, signed |
| srcB | input | WIDTH | Second source operand, signed |
| satClear | input | 1 | Clears the sticky saturation indicator |
| resValid | output | 1 | Result delivered this cycle |
| resData | output | WIDTH | Exact or clamped result |
| flagOvf | output | 1 | Overflow of the delivered operation |
| flagNeg | output | 1 | Sign of the delivered value |
| flagZero | output | 1 | Delivered value is zero |
| flagSat | output | 1 | Sticky saturation indicator |

## Verification
The clear of the sticky indicator and a fresh overflow can land on the same clock edge. The two therefore compete for one bit. The bench provokes this by asserting `satClear` together with an overflowing request while the indicator is already high, and again while it is low. It then expects the indicator to read 1 after that edge in both cases. A second pass pairs the clear with a clean operation and expects 0, which shows that the clear still works when no set is competing.

// File: rtl/satarith_pkg.sv
package satarith_pkg;

  // Strobes passed from the control section to the datapath section.
  typedef struct packed {
    logic capture;   // load a new result and its flags
    logic setSat;    // current request overflows
    logic clrSat;    // software clear of the sticky bit
  } satStrobe_t;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } satOp_e;

endpackage

// File: rtl/sat_addsub_datapath.sv
module sat_addsub_datapath
  import satarith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  satStrobe_t       strobe,
  input  logic             opSub,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             ovfNow,
  output logic [WIDTH-1:0] resData,
  output logic             flagOvf,
  output logic             flagNeg,
  output logic             flagZero
);

  localparam int EXT = WIDTH + 1;
  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MAX = {1'b1, {(WIDTH-1){1'b0}}};

  logic [EXT-1:0]   extA;
  logic [EXT-1:0]   extB;
  logic [EXT-1:0]   wide;
  logic [WIDTH-1:0] clampVal;
  logic [WIDTH-1:0] outVal;

  // Sign-extend by one bit so the true sign survives any overflow.
  assign extA = {srcA[WIDTH-1], srcA};
  assign extB = {srcB[WIDTH-1], srcB};

  always_comb begin
    if (satOp_e'(opSub) == OP_SUB) wide = extB - extA;
    else                           wide = extB + extA;
  end

  // Result overflows when the extension bit disagrees with the sign bit.
  assign ovfNow   = wide[EXT-1] ^ wide[WIDTH-1];
  assign clampVal = wide[EXT-1] ? NEG_MAX : POS_MAX;
  assign outVal   = ovfNow ? clampVal : wide[WIDTH-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData  <= '0;
      flagOvf  <= 1'b0;
      flagNeg  <= 1'b0;
      flagZero <= 1'b0;
    end else if (strobe.capture) begin
      resData  <= outVal;
      flagOvf  <= ovfNow;
      flagNeg  <= outVal[WIDTH-1];
      flagZero <= (outVal == '0);
    end
  end

endmodule

// File: rtl/sat_addsub_control.sv
module sat_addsub_control
  import satarith_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       satClear,
  input  logic       ovfNow,
  output satStrobe_t strobe,
  output logic       resValid,
  output logic       flagSat
);

  always_comb begin
    strobe.capture = opValid;
    strobe.setSat  = opValid & ovfNow;
    strobe.clrSat  = satClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      flagSat  <= 1'b0;
    end else begin
      resValid <= strobe.capture;
      // A set in the same cycle as a clear takes priority.
      if (strobe.setSat)      flagSat <= 1'b1;
      else if (strobe.clrSat) flagSat <= 1'b0;
    end
  end

endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import satarith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic             opSub,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic             satClear,
  output logic             resValid,
  output logic [WIDTH-1:0] resData,
  output logic             flagOvf,
  output logic             flagNeg,
  output logic             flagZero,
  output logic             flagSat
);

  satStrobe_t strobe;
  logic       ovfNow;

  sat_addsub_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .satClear (satClear),
    .ovfNow   (ovfNow),
    .strobe   (strobe),
    .resValid (resValid),
    .flagSat  (flagSat)
  );

  sat_addsub_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opSub    (opSub),
    .srcA     (srcA),
    .srcB     (srcB),
    .ovfNow   (ovfNow),
    .resData  (resData),
    .flagOvf  (flagOvf),
    .flagNeg  (flagNeg),
    .flagZero (flagZero)
  );

endmodule

// File: rtl/sat_addsub_checker.sv
module sat_addsub_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             satClear,
  input logic             resValid,
  input logic [WIDTH-1:0] resData,
  input logic             flagOvf,
  input logic             flagNeg,
  input logic             flagZero,
  input logic             flagSat
);

  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MAX = {1'b1, {(WIDTH-1){1'b0}}};

  // R1: a request is answered on the next cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  // R3: an overflowing result sits at one of the two extremes
  a_r3_clamp_extreme: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && flagOvf) |-> (resData == POS_MAX || resData == NEG_MAX));

  // R5: an overflow is always visible in the sticky bit
  a_r5_sat_on_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && flagOvf) |-> flagSat);

  // R5: sticky bit only falls through a clear
  a_r5_sat_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagSat && !satClear) |=> flagSat);

  // R6: clear with no request drops the sticky bit
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (satClear && !opValid) |=> !flagSat);

  // R7: sign flag tracks the written value
  a_r7_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (flagNeg == resData[WIDTH-1]));

  // R9: idle cycles leave the result untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(resData) && $stable(flagZero)));

endmodule

bind sat_addsub_unit sat_addsub_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .satClear (satClear),
  .resValid (resValid),
  .resData  (resData),
  .flagOvf  (flagOvf),
  .flagNeg  (flagNeg),
  .flagZero (flagZero),
  .flagSat  (flagSat)
);

// File: tb/test_sat_addsub_unit.sv
module test_sat_addsub_unit;

  localparam int W = 32;
  localparam logic [W-1:0] PMAX = 32'h7FFF_FFFF;
  localparam logic [W-1:0] NMAX = 32'h8000_0000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic         opSub = 1'b0;
  logic [W-1:0] srcA = '0;
  logic [W-1:0] srcB = '0;
  logic         satClear = 1'b0;
  logic         resValid;
  logic [W-1:0] resData;
  logic         flagOvf, flagNeg, flagZero, flagSat;

  int checks = 0;
  int errors = 0;
  logic expSat = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  sat_addsub_unit #(.WIDTH(W)) i_sat_addsub_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSub(opSub),
    .srcA(srcA), .srcB(srcB), .satClear(satClear),
    .resValid(resValid), .resData(resData), .flagOvf(flagOvf),
    .flagNeg(flagNeg), .flagZero(flagZero), .flagSat(flagSat)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: 64-bit exact arithmetic, then clamp.
  task automatic refModel(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                          output logic [W-1:0] val, output bit ovf);
    longint la, lb, full;
    la = longint'($signed(a));
    lb = longint'($signed(b));
    full = sub ? (lb - la) : (lb + la);
    ovf = 1'b1;
    if (full > 64'sd2147483647)       val = PMAX;
    else if (full < -64'sd2147483648) val = NMAX;
    else begin val = full[W-1:0]; ovf = 1'b0; end
  endtask

  // One request, optionally with a simultaneous clear; checks everything.
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                       input bit clr, input string tag);
    logic [W-1:0] ev; bit eo;
    refModel(a, b, sub, ev, eo);
    @(negedge clk);
    srcA = a; srcB = b; opSub = sub; opValid = 1'b1; satClear = clr;
    @(negedge clk);
    opValid = 1'b0; satClear = 1'b0;
    if (eo) expSat = 1'b1; else if (clr) expSat = 1'b0;
    check(resValid == 1'b1, {tag, " R1 valid"}, 64'(resValid), 64'd1);
    check(resData == ev, {tag, eo ? " R3 clamp" : (sub ? " R2 diff" : " R1 sum")}, 64'(resData), 64'(ev));
    check(flagOvf == eo, {tag, " R4 ovf"}, 64'(flagOvf), 64'(eo));
    check(flagNeg == ev[W-1] && flagZero == (ev == '0), {tag, " R7 flags"},
          64'({flagNeg, flagZero}), 64'({ev[W-1], ev == '0}));
    check(flagSat == expSat, {tag, " R5 R6 sat"}, 64'(flagSat), 64'(expSat));
  endtask

  task automatic tReset();
    check({resValid, resData, flagOvf, flagNeg, flagZero, flagSat} == '0, "R8 reset",
          64'({resValid, flagOvf, flagNeg, flagZero, flagSat}), 64'd0);
    check(resData == '0, "R8 reset data", 64'(resData), 64'd0);
  endtask

  task automatic tBasic();
    runOp(32'd5, 32'd7, 1'b0, 1'b0, "add small");
    runOp(32'd5, 32'd7, 1'b1, 1'b0, "sub order R2");        // 7-5 = 2
    runOp(32'd9, 32'd4, 1'b1, 1'b0, "sub negative");        // -5
    runOp(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "add to zero"); // 0
  endtask

  task automatic tBoundaries();
    runOp(32'd1, PMAX, 1'b0, 1'b0, "max plus one");
    runOp(32'd1, NMAX, 1'b1, 1'b0, "min minus one");
    runOp(PMAX, NMAX, 1'b1, 1'b0, "min minus max");
    runOp(NMAX, 32'd0, 1'b1, 1'b0, "zero minus min");
    runOp(NMAX, NMAX, 1'b0, 1'b0, "min plus min");
    runOp(PMAX, 32'd0, 1'b1, 1'b0, "zero minus max exact");
  endtask

  task automatic tSticky();
    runOp(32'd3, 32'd4, 1'b0, 1'b0, "R5 clean after ovf");
    runOp(32'd3, 32'd4, 1'b0, 1'b1, "R6 clear with clean op");
    runOp(32'd1, PMAX, 1'b0, 1'b1, "R6 clear with ovf (low)");
    runOp(32'd1, PMAX, 1'b0, 1'b1, "R6 clear with ovf (high)");
    // Clear alone, no request.
    @(negedge clk); satClear = 1'b1;
    @(negedge clk); satClear = 1'b0; expSat = 1'b0;
    check(flagSat == 1'b0, "R6 clear idle", 64'(flagSat), 64'd0);
  endtask

  task automatic tIdle();
    logic [W-1:0] held;
    held = resData;
    @(negedge clk);
    srcA = 32'h1234_5678; srcB = 32'h0BAD_F00D; opSub = 1'b1;
    repeat (3) @(negedge clk);
    check(resValid == 1'b0, "R9 no valid", 64'(resValid), 64'd0);
    check(resData == held, "R9 hold", 64'(resData), 64'(held));
  endtask

  task automatic tRandom();
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 4 == 1) a = {a[W-1], {(W-1){~a[W-1]}}} ^ 32'(i % 3);
      runOp(a, b, (i % 2) == 1, (i % 7) == 0, "random");
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tBasic();
    tBoundaries();
    tSticky();
    tIdle();
    tRandom();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule